// File: doc/BRIEF.md
# Standby Log Replay Controller

This controller sits between the compute core of a standby unit and the outside world. While the on-line unit runs normally, every input the core takes and every output it emits is recorded, in order, into a first-in first-out journal. Each journal slot holds one data word and a kind bit that tells an input event from an output event. A checkpoint acknowledgement empties the journal, so it only ever holds what happened after the latest known-good state.

When the on-line unit fails, recovery is requested. The controller first waits until the core reports that the checkpoint state has been restored. Only then does it replay. Input requests from the core are answered from the journal, not from the live port. Outputs that the core produces again are matched against the recorded outputs and held back, so the world sees each output once. When the journal runs dry, the controller signals completion and passes traffic through live.

A journal that overflows raises a sticky request for a full checkpoint. A replayed output that differs from its recorded counterpart, or that arrives where the journal expects an input, raises a sticky divergence error.

Top module: `standby_replay_ctrl`

## Requirements
- R1: After reset the controller is in logging mode with an empty journal, `rec_done`, `full_ckpt_req` and `div_err` low, and `ext_out_valid` equal to `core_out_valid`.
- R2: In logging mode `core_in_data` equals `live_in_data` and `ext_out_valid`/`ext_out_data` follow `core_out_valid`/`core_out_data` in the same cycle; each input request and each core output is appended to the journal (kind bit 0 for input, 1 for output).
- R3: After `rec_start` in logging mode, `ext_out_valid` stays low and input requests are served from `live_in_data` without consuming the journal until a cycle with `restore_done` has passed.
- R4: During replay with a non-empty journal, each `core_in_req` whose journal head is an input entry is answered on `core_in_data` with that entry's data, in recording order, and `live_in_data` is ignored.
- R5: During replay with a non-empty journal, `ext_out_valid` is low; a core output matching the next recorded output entry removes that entry and leaves `div_err` low.
- R6: During replay, a core output whose data differs from the next recorded output, or that finds no output entry next in line, or an input request that finds an output entry at the head, sets `div_err` from the next cycle until reset.
- R7: In the first replay cycle that sees an empty journal, `rec_done` is high for exactly that cycle and traffic passes through live; the controller then stays in live mode, where nothing is recorded, until `ckpt_ack` returns it to logging mode.
- R8: `ckpt_ack` in logging or live mode empties the journal; events of the acknowledge cycle itself in logging mode become the first journal entries.
- R9: The journal holds `DEPTH` entries; an event that finds it full is dropped and sets `full_ckpt_req` from the next cycle, held until the next `ckpt_ack`.
- R10: An input request and a core output in the same cycle are recorded input first, and in replay the pair is consumed in one cycle from two consecutive entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ckpt_ack | input | 1 | New checkpoint taken: empty the journal |
| rec_start | input | 1 | Begin recovery, wait for state restore |
| restore_done | input | 1 | Checkpoint state restored, replay may start |
| live_in_data | input | W | Live input value from the world |
| core_in_req | input | 1 | Core takes an input this cycle |
| core_in_data | output | W | Input value handed to the core |
| core_out_valid | input | 1 | Core emits an output this cycle |
| core_out_data | input | W | Core output value |
| ext_out_valid | output | 1 | Output visible to the world |
| ext_out_data | output | W | Output value to the world |
| rec_done | output | 1 | One-cycle pulse: journal drained, live operation resumes |
| full_ckpt_req | output | 1 | Sticky journal overflow, full checkpoint needed |
| div_err | output | 1 | Sticky replay divergence |

## Verification
A wrong journal pointer or count shows in the very cycle of the next replayed input request as a value on `core_in_data` that is out of order or stale, and a wrong count also moves the `rec_done` pulse earlier or later than the number of recorded events predicts. A wrong mode shows at once as an output leaking onto `ext_out_valid` during the wait or replay, or as events recorded in live mode that later surface as extra replayed inputs. Error flags are registered, so a missed or spurious divergence or overflow is visible one cycle after the event that caused it.

// File: rtl/rlog_pkg.sv
package rlog_pkg;
  typedef enum logic [1:0] {
    ST_LOG    = 2'd0,
    ST_WAIT   = 2'd1,
    ST_REPLAY = 2'd2,
    ST_LIVE   = 2'd3
  } rlog_state_e;
endpackage

// File: rtl/rlog_fifo.sv
module rlog_fifo #(
  parameter int DEPTH = 16,
  parameter int EW    = 9,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [1:0]    push_n,
  input  logic [EW-1:0] ent_a,
  input  logic [EW-1:0] ent_b,
  input  logic [1:0]    pop_n,
  output logic [EW-1:0] head0,
  output logic [EW-1:0] head1,
  output logic [CW-1:0] count,
  output logic          ovf
);
  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] rptr_q, wptr_q, rbase, wbase, rptr_d, wptr_d;
  logic [CW-1:0] cnt_q, cbase, free, req, acc, cnt_d;
  logic          wr_a, wr_b, upd;

  always_comb begin
    rbase = clr ? '0 : rptr_q;
    wbase = clr ? '0 : wptr_q;
    cbase = clr ? '0 : cnt_q;
    free  = CW'(DEPTH) - cbase;
    req   = CW'(push_n);
    if (req > free) begin
      acc = free;
      ovf = 1'b1;
    end else begin
      acc = req;
      ovf = 1'b0;
    end
    wr_a   = (acc != '0);
    wr_b   = (acc[CW-1:1] != '0);
    cnt_d  = cbase + acc - CW'(pop_n);
    rptr_d = rbase + AW'(pop_n);
    wptr_d = wbase + AW'(acc);
    upd    = clr | (|push_n) | (|pop_n);
  end

  always_ff @(posedge clk) begin
    if (wr_a) mem[wbase] <= ent_a;
    if (wr_b) mem[wbase + AW'(1)] <= ent_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      rptr_q <= rptr_d;
      wptr_q <= wptr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head0 = mem[rptr_q];
  assign head1 = mem[rptr_q + AW'(1)];
  assign count = cnt_q;
endmodule

// File: rtl/rlog_fsm.sv
module rlog_fsm
  import rlog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rec_start,
  input  logic        restore_done,
  input  logic        ckpt_ack,
  input  logic        log_empty,
  output rlog_state_e state_q
);
  rlog_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_LOG:    if (rec_start)    state_d = ST_WAIT;
      ST_WAIT:   if (restore_done) state_d = ST_REPLAY;
      ST_REPLAY: if (log_empty)    state_d = ST_LIVE;
      ST_LIVE:   if (ckpt_ack)     state_d = ST_LOG;
      default:                     state_d = ST_LOG;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_LOG;
    else if (state_d != state_q) state_q <= state_d;
  end
endmodule

// File: rtl/rlog_replay.sv
module rlog_replay
  import rlog_pkg::*;
#(
  parameter int W = 8,
  localparam int EW = W + 1
) (
  input  rlog_state_e   state,
  input  logic          has1,
  input  logic          has2,
  input  logic [EW-1:0] head0,
  input  logic [EW-1:0] head1,
  input  logic          core_in_req,
  input  logic [W-1:0]  live_in,
  input  logic          core_out_valid,
  input  logic [W-1:0]  core_out_data,
  output logic [W-1:0]  core_in_data,
  output logic          ext_out_valid,
  output logic [1:0]    push_n,
  output logic [EW-1:0] ent_a,
  output logic [EW-1:0] ent_b,
  output logic [1:0]    pop_n,
  output logic          div_hit
);
  logic          in_hit, out_hit, cand_ok;
  logic [EW-1:0] cand;

  always_comb begin
    core_in_data  = live_in;
    ext_out_valid = core_out_valid;
    push_n        = 2'd0;
    ent_a         = {1'b0, live_in};
    ent_b         = {1'b1, core_out_data};
    pop_n         = 2'd0;
    div_hit       = 1'b0;
    in_hit        = 1'b0;
    out_hit       = 1'b0;
    cand          = '0;
    cand_ok       = 1'b0;
    unique case (state)
      ST_LOG: begin
        if (core_in_req && core_out_valid) begin
          push_n = 2'd2;
        end else if (core_in_req) begin
          push_n = 2'd1;
        end else if (core_out_valid) begin
          push_n = 2'd1;
          ent_a  = {1'b1, core_out_data};
        end
      end
      ST_WAIT: ext_out_valid = 1'b0;
      ST_REPLAY: begin
        if (has1) begin
          ext_out_valid = 1'b0;
          in_hit = core_in_req && !head0[W];
          if (core_in_req && head0[W]) div_hit = 1'b1;
          if (in_hit) core_in_data = head0[W-1:0];
          cand    = in_hit ? head1 : head0;
          cand_ok = in_hit ? has2 : 1'b1;
          if (core_out_valid) begin
            if (cand_ok && cand[W]) begin
              out_hit = 1'b1;
              if (cand[W-1:0] != core_out_data) div_hit = 1'b1;
            end else begin
              div_hit = 1'b1;
            end
          end
          pop_n = {1'b0, in_hit} + {1'b0, out_hit};
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/standby_replay_ctrl.sv
module standby_replay_ctrl
  import rlog_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int EW   = W + 1,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ckpt_ack,
  input  logic         rec_start,
  input  logic         restore_done,
  input  logic [W-1:0] live_in_data,
  input  logic         core_in_req,
  output logic [W-1:0] core_in_data,
  input  logic         core_out_valid,
  input  logic [W-1:0] core_out_data,
  output logic         ext_out_valid,
  output logic [W-1:0] ext_out_data,
  output logic         rec_done,
  output logic         full_ckpt_req,
  output logic         div_err
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  rlog_state_e   state_q;
  logic [EW-1:0] head0, head1, ent_a, ent_b;
  logic [CW-1:0] log_cnt;
  logic [1:0]    push_n, pop_n;
  logic          log_empty, clr, fifo_ovf, div_hit;
  logic          ovf_q, div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign log_empty = (log_cnt == '0);
  assign clr       = ckpt_ack && ((state_q == ST_LOG) || (state_q == ST_LIVE));

  rlog_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .rec_start    (rec_start),
    .restore_done (restore_done),
    .ckpt_ack     (ckpt_ack),
    .log_empty    (log_empty),
    .state_q      (state_q)
  );

  rlog_fifo #(.DEPTH(DEPTH), .EW(EW)) u_log (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (clr),
    .push_n (push_n),
    .ent_a  (ent_a),
    .ent_b  (ent_b),
    .pop_n  (pop_n),
    .head0  (head0),
    .head1  (head1),
    .count  (log_cnt),
    .ovf    (fifo_ovf)
  );

  rlog_replay #(.W(W)) u_rep (
    .state          (state_q),
    .has1           (log_cnt != '0),
    .has2           (log_cnt > CW'(1)),
    .head0          (head0),
    .head1          (head1),
    .core_in_req    (core_in_req),
    .live_in        (live_in_data),
    .core_out_valid (core_out_valid),
    .core_out_data  (core_out_data),
    .core_in_data   (core_in_data),
    .ext_out_valid  (ext_out_valid),
    .push_n         (push_n),
    .ent_a          (ent_a),
    .ent_b          (ent_b),
    .pop_n          (pop_n),
    .div_hit        (div_hit)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ovf_q <= 1'b0;
    end else if (fifo_ovf) begin
      ovf_q <= 1'b1;
    end else if (clr) begin
      ovf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   div_q <= 1'b0;
    else if (div_hit) div_q <= 1'b1;
  end

  assign ext_out_data  = core_out_data;
  assign rec_done      = (state_q == ST_REPLAY) && log_empty;
  assign full_ckpt_req = ovf_q;
  assign div_err       = div_q;
endmodule

// File: rtl/rlog_checker.sv
module rlog_checker
  import rlog_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input rlog_state_e   state,
  input logic [CW-1:0] log_count,
  input logic          ckpt_ack,
  input logic          ext_out_valid,
  input logic          rec_done,
  input logic          full_ckpt_req,
  input logic          div_err
);
  p_wait_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> !ext_out_valid);

  p_wait_keeps_log_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |=> $stable(log_count));

  p_replay_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_REPLAY) && (log_count != '0)) |-> !ext_out_valid);

  p_div_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |=> div_err);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |=> (!rec_done && (state == ST_LIVE)));

  p_live_keeps_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_LIVE) && (log_count == '0)) |=> (log_count == '0));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    log_count <= CW'(DEPTH));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full_ckpt_req && !ckpt_ack) |=> full_ckpt_req);
endmodule

bind standby_replay_ctrl rlog_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .state         (state_q),
  .log_count     (log_cnt),
  .ckpt_ack      (ckpt_ack),
  .ext_out_valid (ext_out_valid),
  .rec_done      (rec_done),
  .full_ckpt_req (full_ckpt_req),
  .div_err       (div_err)
);

// File: tb/sim_standby_replay_ctrl.sv
`timescale 1ns/1ps
module sim_standby_replay_ctrl;
  localparam int W     = 8;
  localparam int DEPTH = 16;

  logic         clk;
  logic         rst_n;
  logic         ckpt_ack, rec_start, restore_done;
  logic [W-1:0] live_in_data, core_out_data;
  logic         core_in_req, core_out_valid;
  logic [W-1:0] core_in_data, ext_out_data;
  logic         ext_out_valid, rec_done, full_ckpt_req, div_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  standby_replay_ctrl #(.W(W), .DEPTH(DEPTH)) u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .ckpt_ack       (ckpt_ack),
    .rec_start      (rec_start),
    .restore_done   (restore_done),
    .live_in_data   (live_in_data),
    .core_in_req    (core_in_req),
    .core_in_data   (core_in_data),
    .core_out_valid (core_out_valid),
    .core_out_data  (core_out_data),
    .ext_out_valid  (ext_out_valid),
    .ext_out_data   (ext_out_data),
    .rec_done       (rec_done),
    .full_ckpt_req  (full_ckpt_req),
    .div_err        (div_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    ckpt_ack = 0; rec_start = 0; restore_done = 0;
    core_in_req = 0; core_out_valid = 0;
    live_in_data = '0; core_out_data = '0;
  endtask

  task automatic drive_in(input logic [W-1:0] v);
    idle(); core_in_req = 1; live_in_data = v;
  endtask

  task automatic drive_out(input logic [W-1:0] v);
    idle(); core_out_valid = 1; core_out_data = v;
  endtask

  task automatic enter_replay();
    idle(); rec_start = 1; step();
    idle(); restore_done = 1; step();
    idle();
  endtask

  task automatic t_reset();
    idle(); rst_n = 0;
    repeat (3) step();
    rst_n = 1;
    repeat (3) step();
    core_out_valid = 1; core_out_data = 8'h5A; #1;
    chk("R1 ext_out_valid follows core", ext_out_valid, 1);
    chk("R1 rec_done low", rec_done, 0);
    chk("R1 full_ckpt_req low", full_ckpt_req, 0);
    chk("R1 div_err low", div_err, 0);
    idle(); core_in_req = 1; live_in_data = 8'h3C; #1;
    chk("R1 input from live port", core_in_data, 8'h3C);
    idle();
  endtask

  task automatic t_basic_replay();
    idle(); ckpt_ack = 1; step();
    drive_in(8'h11); #1; chk("R2 live input to core", core_in_data, 8'h11); step();
    drive_out(8'hA1); #1;
    chk("R2 output valid to world", ext_out_valid, 1);
    chk("R2 output data to world", ext_out_data, 8'hA1); step();
    drive_in(8'h22); step();
    drive_in(8'h33); core_out_valid = 1; core_out_data = 8'hA2; #1;
    chk("R10 paired output passes in log mode", ext_out_valid, 1); step();
    idle(); rec_start = 1; step();
    drive_in(8'h99); core_out_valid = 1; core_out_data = 8'hA9; #1;
    chk("R3 no world output while waiting", ext_out_valid, 0);
    chk("R3 live input while waiting", core_in_data, 8'h99); step();
    idle(); restore_done = 1; step(); idle(); #1;
    chk("R3 replay not yet done", rec_done, 0);
    drive_in(8'h55); #1; chk("R4 first replayed input", core_in_data, 8'h11); step();
    drive_out(8'hA1); #1; chk("R5 recorded output held back", ext_out_valid, 0); step();
    drive_in(8'h66); #1; chk("R4 second replayed input", core_in_data, 8'h22); step();
    drive_in(8'h77); core_out_valid = 1; core_out_data = 8'hA2; #1;
    chk("R10 pair input from log", core_in_data, 8'h33);
    chk("R10 pair output held back", ext_out_valid, 0); step();
    drive_out(8'hC3); #1;
    chk("R7 rec_done on empty journal", rec_done, 1);
    chk("R7 output passes once drained", ext_out_valid, 1);
    chk("R5 matched outputs leave div_err low", div_err, 0); step();
    drive_out(8'hC4); #1;
    chk("R7 rec_done is one cycle", rec_done, 0);
    chk("R7 live output passes", ext_out_valid, 1);
    idle();
  endtask

  task automatic t_live_no_log();
    drive_in(8'h77); core_out_valid = 1; core_out_data = 8'hE7; step();
    idle(); ckpt_ack = 1; step();
    drive_in(8'h44); step();
    enter_replay();
    drive_in(8'h00); #1;
    chk("R7 live events not recorded", core_in_data, 8'h44); step();
    idle(); #1; chk("R8 journal emptied by ack in live mode", rec_done, 1); step();
    idle(); ckpt_ack = 1; step(); idle();
  endtask

  task automatic t_ack_clear();
    drive_in(8'h01); step();
    drive_in(8'h02); ckpt_ack = 1; step();
    enter_replay();
    drive_in(8'hFF); #1;
    chk("R8 ack-cycle event is first entry", core_in_data, 8'h02); step();
    idle(); #1; chk("R8 only ack-cycle entry kept", rec_done, 1); step();
    idle(); ckpt_ack = 1; step(); idle();
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DEPTH; i++) begin
      drive_in(8'(i)); step();
    end
    idle(); #1; chk("R9 full journal is no overflow", full_ckpt_req, 0);
    drive_in(8'hEE); step();
    idle(); #1; chk("R9 overflow flag set", full_ckpt_req, 1); step();
    #1; chk("R9 overflow flag holds", full_ckpt_req, 1);
    enter_replay();
    for (int i = 0; i < DEPTH; i++) begin
      drive_in(8'hF0); #1;
      chk("R9 kept entries in order", core_in_data, 32'(i)); step();
    end
    idle(); #1; chk("R9 dropped entry absent", rec_done, 1); step();
    #1; chk("R9 flag holds until ack", full_ckpt_req, 1);
    ckpt_ack = 1; step(); idle(); #1;
    chk("R9 ack clears overflow flag", full_ckpt_req, 0);
  endtask

  task automatic t_div_data();
    t_reset();
    idle(); ckpt_ack = 1; step();
    drive_out(8'hB0); step();
    enter_replay();
    drive_out(8'hB1); #1; chk("R6 mismatching output held back", ext_out_valid, 0); step();
    idle(); #1; chk("R6 data mismatch sets div_err", div_err, 1); step();
    #1; chk("R6 div_err sticky", div_err, 1);
  endtask

  task automatic t_div_type();
    t_reset();
    idle(); ckpt_ack = 1; step();
    drive_in(8'h10); step();
    enter_replay();
    drive_out(8'hB2); step();
    idle(); #1;
    chk("R6 output against input entry sets div_err", div_err, 1);
    chk("R6 input entry still pending", rec_done, 0);
    drive_in(8'h00); #1; chk("R4 pending input still served", core_in_data, 8'h10); step();
    idle(); #1; chk("R7 drained after pending input", rec_done, 1);
  endtask

  initial begin
    t_reset();
    t_basic_replay();
    t_live_no_log();
    t_ack_clear();
    t_overflow();
    t_div_data();
    t_div_type();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule